// File: doc/BRIEF.md
# USB Full-Speed Packet Receiver

This block recovers packets from the two USB full-speed data lines. A bit-strobe input marks one clock per 12 Mbit/s bit time, and the line pair is sampled only on those clocks. Each sample is classified as J, K, single-ended zero (SE0) or illegal. While the bus is idle the receiver hunts for the sync pattern. Once sync is found it NRZI-decodes the line, drops the stuffed zero after every run of six ones, and packs the bits into bytes, least significant bit first. Each byte comes out with a one-clock valid strobe.

The packet closes with SE0, SE0, J. A one-clock end strobe marks this, and it carries a framing flag when the packet was damaged. A bit-stuff violation raises an error strobe, except when the offending bit is the stray bit that can sit just before the end-of-packet SE0. A long run of SE0 raises a bus-reset level. Clock and data recovery, PID decoding, CRC checking and transmission live elsewhere.

The controller has five states, each with named transitions:

- ST_IDLE:
  - sync lock → ST_DATA
- ST_DATA:
  - SE0 → ST_EOP1
  - illegal sample or stuff violation → ST_ABORT
- ST_ABORT:
  - SE0 → ST_EOP1
- ST_EOP1:
  - second SE0 → ST_EOP2
  - anything else → ST_ABORT
- ST_EOP2:
  - J → ST_IDLE (packet end)
  - K or illegal → ST_ABORT
  - SE0 → stays in ST_EOP2

From any state, a bus reset returns the receiver to ST_IDLE.

Top module: `usbfs_rx`

## Requirements
- R1: The pair {line_p,line_m} is read as 10 = J, 01 = K, 00 = SE0 and 11 = illegal. Each illegal sample pulses line_err for one clock. In ST_DATA, ST_EOP1 and ST_EOP2 an illegal sample also aborts the packet.
- R2: In idle, sync lock needs two things: a decoded 1 on a K sample, and at least SYNC_ZEROS consecutive decoded 0s just before it (default 7, so the pattern is KJKJKJKK). On lock, pkt_start pulses and rx_active goes high, both one clock after that sample. Any other idle activity produces no output.
- R3: A line state equal to the previous J/K state decodes as 1, and a change decodes as 0. Data bits fill bytes LSB first. byte_vld pulses, with byte_o, one clock after the sample carrying the eighth bit.
- R4: After STUFF_RUN (6) consecutive decoded 1s, the next decoded 0 is dropped. The ones count is cleared by any decoded 0 and at sync lock. Sync bits are never destuffed.
- R5: A decoded 1 where a stuffed 0 is due is a violation. The violation is reported as a stuff_err pulse at the next sample, unless that sample is SE0. After the report, data is ignored until the end-of-packet; rx_active stays high.
- R6: A violating bit that is directly followed by SE0 is dropped, and no error is reported.
- R7: SE0, SE0, J ends the packet. pkt_end pulses and rx_active falls, both one clock after the J sample.
- R8: frame_err pulses together with pkt_end when the packet ends with a partial byte, or after an abort.
- R9: bus_rst rises one clock after the RST_BITS-th consecutive SE0 sample. It stays high until a non-SE0 sample. The rise returns the receiver to idle without a pkt_end.
- R10: After reset all outputs are low and the receiver is idle, with the previous line state taken as J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-clock strobe per bit time; line is sampled when high |
| line_p | input | 1 | D+ line level |
| line_m | input | 1 | D- line level |
| byte_o | output | 8 | Received byte |
| byte_vld | output | 1 | byte_o valid strobe |
| pkt_start | output | 1 | Sync locked strobe |
| pkt_end | output | 1 | End-of-packet strobe |
| stuff_err | output | 1 | Bit-stuff violation strobe |
| frame_err | output | 1 | Damaged-packet flag, with pkt_end |
| line_err | output | 1 | Illegal line state strobe |
| bus_rst | output | 1 | Bus reset level |
| rx_active | output | 1 | Packet in progress |

## Verification
A wrong ones count shows up at the ports within one byte. Either a stuffed zero leaks into byte_o, or a legal run of six ones raises stuff_err; both appear within eight bit times of the fault. A wrong previous-line register inverts one decoded bit, so the very next byte miscompares. A lost abort or partial-byte flag is only seen at pkt_end, where frame_err is wrong. A wrong SE0 count moves bus_rst by one bit time, and the bench catches that by checking the level one sample before and one sample at the threshold.

// File: rtl/usbfs_rx_pkg.sv
package usbfs_rx_pkg;
    // {line_p, line_m}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_K   = 2'b01,
        LN_J   = 2'b10,
        LN_ILL = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_ABORT,
        ST_EOP1,
        ST_EOP2
    } rx_state_t;
endpackage

// File: rtl/usbfs_nrzi_dec.sv
module usbfs_nrzi_dec
    import usbfs_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_en,
    input  line_t ln,
    output logic  dbit
);
    line_t prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= LN_J;
        end else if (bit_en) begin
            case (ln)
                LN_J, LN_K: prev_q <= ln;
                LN_SE0:     prev_q <= LN_J;
                default:    prev_q <= prev_q;
            endcase
        end
    end

    assign dbit = (ln == prev_q);
endmodule

// File: rtl/usbfs_se0_timer.sv
module usbfs_se0_timer #(
    parameter int RST_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic is_se0,
    output logic reach,
    output logic bus_rst
);
    localparam int TW = $clog2(RST_BITS + 1);

    logic [TW-1:0] cnt_q;

    assign reach = bit_en && is_se0 && (cnt_q == TW'(RST_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bus_rst <= 1'b0;
        end else if (bit_en) begin
            if (!is_se0) begin
                cnt_q   <= '0;
                bus_rst <= 1'b0;
            end else begin
                if (cnt_q != TW'(RST_BITS)) cnt_q <= cnt_q + 1'b1;
                if (reach) bus_rst <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/usbfs_byte_asm.sv
module usbfs_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              din,
    output logic              done,
    output logic [BYTE_W-1:0] word,
    output logic              partial
);
    localparam int CW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;

    assign word    = {din, sh_q[BYTE_W-1:1]};
    assign done    = shift && (cnt_q == CW'(BYTE_W - 1));
    assign partial = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (shift) begin
            sh_q  <= word;
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/usbfs_rx.sv
module usbfs_rx
    import usbfs_rx_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int STUFF_RUN  = 6,
    parameter int SYNC_ZEROS = 7,
    parameter int RST_BITS   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              line_p,
    input  logic              line_m,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld,
    output logic              pkt_start,
    output logic              pkt_end,
    output logic              stuff_err,
    output logic              frame_err,
    output logic              line_err,
    output logic              bus_rst,
    output logic              rx_active
);
    localparam int OW = $clog2(STUFF_RUN + 1);
    localparam int ZW = $clog2(SYNC_ZEROS + 1);

    line_t             ln;
    logic              jk, dbit, rst_reach, take, asm_clr, done, partial;
    logic [BYTE_W-1:0] word;
    rx_state_t         st_q, st_d;
    logic [ZW-1:0]     zrun_q, zrun_d;
    logic [OW-1:0]     ones_q, ones_d;
    logic              pend_q, pend_d, abort_q, abort_d;
    logic              ev_start, ev_end, ev_stuff, ev_line, ev_frame;

    assign ln = line_t'({line_p, line_m});
    assign jk = (ln == LN_J) || (ln == LN_K);

    usbfs_nrzi_dec u_dec (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ln(ln), .dbit(dbit)
    );

    usbfs_se0_timer #(.RST_BITS(RST_BITS)) u_se0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .is_se0(ln == LN_SE0),
        .reach(rst_reach), .bus_rst(bus_rst)
    );

    usbfs_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .clr(asm_clr), .shift(take), .din(dbit),
        .done(done), .word(word), .partial(partial)
    );

    // next state and per-sample events
    always_comb begin
        st_d     = st_q;
        zrun_d   = zrun_q;
        ones_d   = ones_q;
        pend_d   = pend_q;
        abort_d  = abort_q;
        take     = 1'b0;
        asm_clr  = 1'b0;
        ev_start = 1'b0;
        ev_end   = 1'b0;
        ev_stuff = 1'b0;
        ev_frame = 1'b0;
        ev_line  = bit_en && (ln == LN_ILL);
        if (bit_en) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (!jk) begin
                        zrun_d = '0;
                    end else if (!dbit) begin
                        if (zrun_q != ZW'(SYNC_ZEROS)) zrun_d = zrun_q + 1'b1;
                    end else begin
                        if (zrun_q == ZW'(SYNC_ZEROS) && ln == LN_K) begin
                            st_d     = ST_DATA;
                            ev_start = 1'b1;
                            asm_clr  = 1'b1;
                            ones_d   = '0;
                            pend_d   = 1'b0;
                            abort_d  = 1'b0;
                        end
                        zrun_d = '0;
                    end
                end
                ST_DATA: begin
                    if (ln == LN_SE0) begin
                        st_d   = ST_EOP1;
                        pend_d = 1'b0;
                    end else if (ln == LN_ILL) begin
                        st_d    = ST_ABORT;
                        abort_d = 1'b1;
                        pend_d  = 1'b0;
                    end else if (pend_q) begin
                        ev_stuff = 1'b1;
                        st_d     = ST_ABORT;
                        abort_d  = 1'b1;
                        pend_d   = 1'b0;
                    end else if (ones_q == OW'(STUFF_RUN)) begin
                        if (dbit) pend_d = 1'b1;
                        else      ones_d = '0;
                    end else begin
                        take   = 1'b1;
                        ones_d = dbit ? ones_q + 1'b1 : '0;
                    end
                end
                ST_ABORT: begin
                    if (ln == LN_SE0) st_d = ST_EOP1;
                end
                ST_EOP1: begin
                    if (ln == LN_SE0) begin
                        st_d = ST_EOP2;
                    end else begin
                        st_d    = ST_ABORT;
                        abort_d = 1'b1;
                    end
                end
                ST_EOP2: begin
                    if (ln == LN_J) begin
                        st_d     = ST_IDLE;
                        ev_end   = 1'b1;
                        ev_frame = abort_q | partial;
                    end else if (ln != LN_SE0) begin
                        st_d    = ST_ABORT;
                        abort_d = 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
            if (st_q != ST_IDLE) zrun_d = '0;
            if (rst_reach) begin
                st_d     = ST_IDLE;
                ev_end   = 1'b0;
                ev_frame = 1'b0;
                zrun_d   = '0;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            zrun_q  <= '0;
            ones_q  <= '0;
            pend_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            zrun_q  <= zrun_d;
            ones_q  <= ones_d;
            pend_q  <= pend_d;
            abort_q <= abort_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_o    <= '0;
            byte_vld  <= 1'b0;
            pkt_start <= 1'b0;
            pkt_end   <= 1'b0;
            stuff_err <= 1'b0;
            frame_err <= 1'b0;
            line_err  <= 1'b0;
        end else begin
            byte_vld  <= take && done;
            pkt_start <= ev_start;
            pkt_end   <= ev_end;
            stuff_err <= ev_stuff;
            frame_err <= ev_frame;
            line_err  <= ev_line;
            if (take && done) byte_o <= word;
        end
    end

    assign rx_active = (st_q != ST_IDLE);
endmodule

// File: rtl/usbfs_rx_chk.sv
module usbfs_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic line_p,
    input logic line_m,
    input logic byte_vld,
    input logic pkt_start,
    input logic pkt_end,
    input logic stuff_err,
    input logic frame_err,
    input logic line_err,
    input logic bus_rst,
    input logic rx_active
);
    // R1
    illegal_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |-> $past(bit_en && line_p && line_m));

    // R2
    start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |-> $rose(rx_active));

    // R3
    byte_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> rx_active);

    // R5
    stuff_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> rx_active);

    // R7
    end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_active) |-> (pkt_end || bus_rst));

    // R7
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);

    // R8
    frame_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> pkt_end);

    // R9
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |-> !rx_active);
endmodule

bind usbfs_rx usbfs_rx_chk u_chk (.*);

// File: tb/sim_usbfs_rx.sv
module sim_usbfs_rx;
    localparam int RST_BITS = 20;
    localparam logic [3:0] K_START = 4'd1, K_BYTE = 4'd2, K_END = 4'd3,
                           K_ENDF = 4'd4, K_STUFF = 4'd5, K_LINE = 4'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       line_p = 1'b1;
    logic       line_m = 1'b0;
    logic [7:0] byte_o;
    logic       byte_vld, pkt_start, pkt_end, stuff_err, frame_err;
    logic       line_err, bus_rst, rx_active;

    int  nvec = 0;
    int  nfail = 0;
    bit  done = 1'b0;
    logic [11:0] expq[$];
    logic lvl = 1'b1;   // 1 = J
    int   ones = 0;

    always #10 clk = ~clk;

    usbfs_rx #(.RST_BITS(RST_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_p(line_p),
        .line_m(line_m), .byte_o(byte_o), .byte_vld(byte_vld),
        .pkt_start(pkt_start), .pkt_end(pkt_end), .stuff_err(stuff_err),
        .frame_err(frame_err), .line_err(line_err), .bus_rst(bus_rst),
        .rx_active(rx_active)
    );

    function automatic string kreq(input logic [3:0] k);
        case (k)
            K_START: return "R2";
            K_BYTE:  return "R3";
            K_END:   return "R7";
            K_ENDF:  return "R8";
            K_STUFF: return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic see(input logic [11:0] obs);
        nvec++;
        if (expq.size() == 0) begin
            nfail++;
            $display("FAIL %s: unexpected event act=%h exp=none", kreq(obs[11:8]), obs);
        end else begin
            logic [11:0] e;
            e = expq.pop_front();
            if (e !== obs) begin
                nfail++;
                $display("FAIL %s: event act=%h exp=%h", kreq(e[11:8]), obs, e);
            end
        end
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_start) see({K_START, 8'h00});
            if (byte_vld)  see({K_BYTE, byte_o});
            if (pkt_end)   see({frame_err ? K_ENDF : K_END, 8'h00});
            if (stuff_err) see({K_STUFF, 8'h00});
            if (line_err)  see({K_LINE, 8'h00});
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drained(input string tag);
        repeat (2) @(negedge clk);
        chk(tag, expq.size(), 0);
        expq.delete();
    endtask

    task automatic smp(input logic p, input logic m);
        @(negedge clk);
        line_p = p; line_m = m; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_lvl(input logic j);
        smp(j, !j);
    endtask

    task automatic nrz(input logic b);
        if (!b) lvl = !lvl;
        send_lvl(lvl);
    endtask

    task automatic dbit(input logic b);
        nrz(b);
        if (b) begin
            ones++;
            if (ones == 6) begin
                nrz(1'b0);
                ones = 0;
            end
        end else begin
            ones = 0;
        end
    endtask

    task automatic sync_tx();
        expq.push_back({K_START, 8'h00});
        for (int i = 0; i < 7; i++) nrz(1'b0);
        nrz(1'b1);
        ones = 0;
    endtask

    task automatic byte_tx(input logic [7:0] b);
        expq.push_back({K_BYTE, b});
        for (int i = 0; i < 8; i++) dbit(b[i]);
    endtask

    task automatic eop_tx(input logic bad);
        expq.push_back({bad ? K_ENDF : K_END, 8'h00});
        smp(1'b0, 1'b0);
        smp(1'b0, 1'b0);
        smp(1'b1, 1'b0);
        lvl = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_lvl(1'b1);
        lvl = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rx_active", rx_active, 0);
        chk("R10 byte_vld", byte_vld, 0);
        chk("R10 bus_rst", bus_rst, 0);
        chk("R10 pkt_end", pkt_end, 0);
        idle(3);

        // R2 R3 R7 basic packet
        sync_tx();
        chk("R2 rx_active after sync", rx_active, 1);
        byte_tx(8'hA5);
        byte_tx(8'h3C);
        chk("R7 active before eop", rx_active, 1);
        eop_tx(1'b0);
        chk("R7 rx_active after eop", rx_active, 0);
        drained("R3 basic packet");

        // R4 stuffing across bytes, back-to-back packet
        sync_tx();
        byte_tx(8'hFF);
        byte_tx(8'hFF);
        byte_tx(8'h7E);
        byte_tx(8'h80);
        eop_tx(1'b0);
        sync_tx();
        byte_tx(8'h01);
        eop_tx(1'b0);
        drained("R4 stuffed packets");
        idle(2);

        // R2 idle noise and short sync ignored
        nrz(1'b0); nrz(1'b1); nrz(1'b0);
        for (int i = 0; i < 5; i++) nrz(1'b0);
        nrz(1'b1);
        chk("R2 no lock on short sync", rx_active, 0);
        nrz(1'b0);
        idle(2);
        drained("R2 idle noise");

        // R5 seven ones
        sync_tx();
        expq.push_back({K_STUFF, 8'h00});
        for (int i = 0; i < 7; i++) nrz(1'b1);
        nrz(1'b0);
        chk("R5 active during abort", rx_active, 1);
        nrz(1'b1); nrz(1'b0); nrz(1'b0);
        eop_tx(1'b1);
        drained("R5 stuff error");
        idle(2);

        // R6 stray bit before SE0
        sync_tx();
        expq.push_back({K_BYTE, 8'hFC});
        nrz(1'b0); nrz(1'b0);
        for (int i = 0; i < 6; i++) nrz(1'b1);
        nrz(1'b1);
        eop_tx(1'b0);
        drained("R6 stray bit ignored");
        idle(2);

        // R8 leftover bits
        sync_tx();
        byte_tx(8'h5A);
        dbit(1'b1); dbit(1'b0); dbit(1'b1);
        eop_tx(1'b1);
        drained("R8 partial byte");
        idle(2);

        // R1 illegal state idle and in packet
        expq.push_back({K_LINE, 8'h00});
        smp(1'b1, 1'b1);
        chk("R1 idle stays idle", rx_active, 0);
        idle(2);
        sync_tx();
        byte_tx(8'h11);
        expq.push_back({K_LINE, 8'h00});
        smp(1'b1, 1'b1);
        chk("R1 abort keeps active", rx_active, 1);
        nrz(1'b0); nrz(1'b1);
        eop_tx(1'b1);
        drained("R1 illegal state");
        idle(2);

        // R9 bus reset in idle
        for (int i = 0; i < RST_BITS - 1; i++) smp(1'b0, 1'b0);
        chk("R9 bus_rst before limit", bus_rst, 0);
        smp(1'b0, 1'b0);
        chk("R9 bus_rst at limit", bus_rst, 1);
        smp(1'b0, 1'b0);
        chk("R9 bus_rst held", bus_rst, 1);
        idle(1);
        chk("R9 bus_rst cleared by J", bus_rst, 0);
        idle(2);

        // R9 bus reset during a packet
        sync_tx();
        byte_tx(8'h42);
        for (int i = 0; i < RST_BITS; i++) smp(1'b0, 1'b0);
        chk("R9 reset ends packet", rx_active, 0);
        chk("R9 bus_rst mid packet", bus_rst, 1);
        idle(3);
        drained("R9 no pkt_end after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule